// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides an input clock by a programmable ratio of the form P×N+A. It is the feedback divider of a frequency synthesizer loop. A prescaler, modelled in logic, divides by either P+1 or P. A swallow counter decides how many prescaler periods use the larger modulus. A main counter sets how many prescaler periods make up one output period. A single select bit picks the prescaler pair, either 32/33 or 64/65.

At the start of every output period the prescaler runs at P+1 for A of its own periods. It then runs at P for the remaining N−A periods. The output gives a single-clock pulse on the last input clock of each output period, and that pulse drives a phase comparator. The three settings are taken in only at a period boundary or during reset. An out-of-range setting is repaired and reported on an error line.

Top module: `swallow_div`

## Requirements
- R1: The interval between consecutive `div_pulse` assertions is P×N+A input clocks. P is 32 when `mod_sel` is 0 and 64 when `mod_sel` is 1.
- R2: `swallow_set` is a 7-bit unsigned count (0 to 127). `main_set` is an 11-bit unsigned count, and any value from 16 to 2047 is used unchanged.
- R3: In every output period, `mod_ctrl` is high for exactly A×(P+1) input clocks, starting at the first clock of the period. It then stays low until the period ends.
- R4: `div_pulse` is high for exactly one input clock per output period: the last clock of the period.
- R5: `mod_sel`, `swallow_set` and `main_set` are sampled only during reset and on the clock edge that ends an output period. A change made in the middle of a period first affects the following period.
- R6: When `swallow_set` ≥ the effective N, `ratio_err` is high and A is taken as N−1. `ratio_err` follows the present input values combinationally.
- R7: When `main_set` is below 16, `ratio_err` is high and N is taken as 16.
- R8: A synchronous high `rst` clears all counters. After release, the first `div_pulse` appears on the (P×N+A)-th clock counted from the release state, and `mod_ctrl` is high in that first state whenever A > 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_sel | input | 1 | Prescaler pair select: 0 gives 32/33, 1 gives 64/65 |
| swallow_set | input | 7 | Swallow count A |
| main_set | input | 11 | Main count N |
| div_pulse | output | 1 | One-clock divided output pulse |
| mod_ctrl | output | 1 | High while the prescaler divides by P+1 |
| ratio_err | output | 1 | Present settings are out of range and have been clamped |

## Verification
The bench measures whole periods and counts the `mod_ctrl` high clocks in each one. If the swallow phase were counted in input clocks rather than prescaler periods, the ratio would come out as P×N plus a few clocks instead of P×N+A. The clamp cases use A equal to N and A above N. A design that did not clamp would let the swallow phase run past the last main count, which changes the period and leaves `mod_ctrl` high across the boundary. Settings are also rewritten mid-period, and reset is applied mid-period. A design that loaded settings at once would produce a hybrid first period, and one that kept stale counts after reset would pulse early.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned A_W         = 7;
  localparam int unsigned N_W         = 11;
  localparam int unsigned N_FLOOR     = 16;
  localparam int unsigned P_SMALL_DEF = 32;
  localparam int unsigned P_LARGE_DEF = 64;
  localparam int unsigned PC_W        = $clog2(P_LARGE_DEF + 2);

  // Main count actually used: values under the floor are raised to it.
  function automatic logic [N_W-1:0] eff_main(input logic [N_W-1:0] n);
    if (n < N_W'(N_FLOOR)) return N_W'(N_FLOOR);
    return n;
  endfunction

  // Swallow count actually used: kept strictly below the effective main count.
  function automatic logic [A_W-1:0] eff_swallow(input logic [A_W-1:0] a,
                                                 input logic [N_W-1:0] n);
    logic [N_W-1:0] a_wide;
    a_wide = N_W'(a);
    if (a_wide >= n) return A_W'(n - N_W'(1));
    return a;
  endfunction

  // Total input clocks per output period.
  function automatic int unsigned period_len(input int unsigned p,
                                             input int unsigned n,
                                             input int unsigned a);
    return p * n + a;
  endfunction
endpackage

// File: rtl/swd_settings.sv
module swd_settings
  import swd_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           sel_in,
  input  logic [A_W-1:0] a_in,
  input  logic [N_W-1:0] n_in,
  output logic           sel_q,
  output logic [A_W-1:0] a_q,
  output logic [N_W-1:0] n_q,
  output logic           err
);
  logic [N_W-1:0] n_fix;
  logic [A_W-1:0] a_fix;

  always_comb begin
    n_fix = eff_main(n_in);
    a_fix = eff_swallow(a_in, n_fix);
    err   = (n_fix != n_in) || (a_fix != a_in);
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      sel_q <= sel_in;
      a_q   <= a_fix;
      n_q   <= n_fix;
    end
  end
endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler
  import swd_pkg::*;
#(
  parameter int unsigned P_SMALL = P_SMALL_DEF,
  parameter int unsigned P_LARGE = P_LARGE_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic            swallow_on,
  output logic            tc,
  output logic [PC_W-1:0] count
);
  localparam logic [PC_W-1:0] LAST_S = PC_W'(P_SMALL - 1);
  localparam logic [PC_W-1:0] LAST_L = PC_W'(P_LARGE - 1);

  logic [PC_W-1:0] last_idx;

  always_comb begin
    last_idx = sel ? LAST_L : LAST_S;
    if (swallow_on) last_idx = last_idx + PC_W'(1);
    tc = (count == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst || tc) count <= '0;
    else           count <= count + PC_W'(1);
  end
endmodule

// File: rtl/swd_swallow_ctr.sv
module swd_swallow_ctr
  import swd_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           restart,
  input  logic [A_W-1:0] limit,
  output logic           phase_on,
  output logic [A_W-1:0] count
);
  assign phase_on = (count != limit);

  always_ff @(posedge clk) begin
    if (rst || restart)          count <= '0;
    else if (step && phase_on)   count <= count + A_W'(1);
  end
endmodule

// File: rtl/swd_main_ctr.sv
module swd_main_ctr
  import swd_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic [N_W-1:0] limit,
  output logic           last,
  output logic           wrap,
  output logic [N_W-1:0] count
);
  assign last = (count == limit - N_W'(1));
  assign wrap = step && last;

  always_ff @(posedge clk) begin
    if (rst || wrap) count <= '0;
    else if (step)   count <= count + N_W'(1);
  end
endmodule

// File: rtl/swallow_div.sv
module swallow_div
  import swd_pkg::*;
#(
  parameter int unsigned P_SMALL = P_SMALL_DEF,
  parameter int unsigned P_LARGE = P_LARGE_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mod_sel,
  input  logic [A_W-1:0] swallow_set,
  input  logic [N_W-1:0] main_set,
  output logic           div_pulse,
  output logic           mod_ctrl,
  output logic           ratio_err
);
  // Named internal events, also observed by the bound checker.
  logic            sel_act;
  logic [A_W-1:0]  a_act;
  logic [N_W-1:0]  n_act;
  logic            pre_tc;
  logic [PC_W-1:0] pre_cnt;
  logic            swallow_on;
  logic [A_W-1:0]  sw_cnt;
  logic            main_last;
  logic            period_end;
  logic [N_W-1:0]  main_cnt;

  swd_settings u_set (
    .clk(clk), .rst(rst), .load(period_end),
    .sel_in(mod_sel), .a_in(swallow_set), .n_in(main_set),
    .sel_q(sel_act), .a_q(a_act), .n_q(n_act), .err(ratio_err)
  );

  swd_prescaler #(.P_SMALL(P_SMALL), .P_LARGE(P_LARGE)) u_pre (
    .clk(clk), .rst(rst), .sel(sel_act), .swallow_on(swallow_on),
    .tc(pre_tc), .count(pre_cnt)
  );

  swd_swallow_ctr u_swl (
    .clk(clk), .rst(rst), .step(pre_tc), .restart(period_end),
    .limit(a_act), .phase_on(swallow_on), .count(sw_cnt)
  );

  swd_main_ctr u_main (
    .clk(clk), .rst(rst), .step(pre_tc), .limit(n_act),
    .last(main_last), .wrap(period_end), .count(main_cnt)
  );

  assign div_pulse = period_end;
  assign mod_ctrl  = swallow_on;
endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk
  import swd_pkg::*;
#(
  parameter int unsigned P_LARGE = P_LARGE_DEF
) (
  input logic            clk,
  input logic            rst,
  input logic            div_pulse,
  input logic            mod_ctrl,
  input logic            sel_act,
  input logic [A_W-1:0]  a_act,
  input logic [N_W-1:0]  n_act,
  input logic [PC_W-1:0] pre_cnt,
  input logic [A_W-1:0]  sw_cnt,
  input logic [N_W-1:0]  main_cnt
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse); // R4

  AST_MOD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> (mod_ctrl == (a_act != '0))); // R3

  AST_MOD_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!mod_ctrl && !div_pulse) |=> !mod_ctrl); // R3

  AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !div_pulse |=> ($stable(a_act) && $stable(n_act) && $stable(sel_act))); // R5

  AST_SWALLOW_BELOW_MAIN: assert property (@(posedge clk) disable iff (rst)
    N_W'(a_act) < n_act); // R6

  AST_MAIN_FLOOR: assert property (@(posedge clk) disable iff (rst)
    n_act >= N_W'(N_FLOOR)); // R7

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PC_W'(P_LARGE)); // R1

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pre_cnt == '0 && sw_cnt == '0 && main_cnt == '0)); // R8
endmodule

bind swallow_div swallow_div_chk u_chk (
  .clk(clk), .rst(rst), .div_pulse(div_pulse), .mod_ctrl(mod_ctrl),
  .sel_act(sel_act), .a_act(a_act), .n_act(n_act),
  .pre_cnt(pre_cnt), .sw_cnt(sw_cnt), .main_cnt(main_cnt)
);

// File: tb/swallow_div_test.sv
module swallow_div_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_sel = 1'b0;
  logic [6:0]  swallow_set = '0;
  logic [10:0] main_set = 11'd16;
  logic        div_pulse, mod_ctrl, ratio_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  swallow_div uut (
    .clk(clk), .rst(rst), .mod_sel(mod_sel), .swallow_set(swallow_set),
    .main_set(main_set), .div_pulse(div_pulse), .mod_ctrl(mod_ctrl),
    .ratio_err(ratio_err)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  // Expected clamp rules and period, written from the requirements.
  function automatic int exp_n(input int n);
    return (n < 16) ? 16 : n;
  endfunction
  function automatic int exp_a(input int a, input int n);
    int ne = exp_n(n);
    return (a >= ne) ? ne - 1 : a;
  endfunction
  function automatic int exp_p(input bit s);
    return s ? 64 : 32;
  endfunction
  function automatic int exp_gap(input bit s, input int a, input int n);
    return exp_p(s) * exp_n(n) + exp_a(a, n);
  endfunction
  function automatic int exp_hi(input bit s, input int a, input int n);
    return exp_a(a, n) * (exp_p(s) + 1);
  endfunction

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input bit s, input int a, input int n);
    mod_sel     = s;
    swallow_set = 7'(a);
    main_set    = 11'(n);
  endtask

  // Reset with given settings; returns at a falling edge with rst low.
  task automatic do_reset(input bit s, input int a, input int n);
    @(negedge clk);
    apply(s, a, n);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Rising edges from now until the pulse is seen.
  task automatic to_pulse(output int cnt);
    cnt = 0;
    while (!div_pulse && cnt < 40000) begin
      @(posedge clk); @(negedge clk); cnt++;
    end
  endtask

  // Called at a pulse: measures the next full period.
  task automatic next_gap(output int gap, output int hi, output bit first_low);
    gap = 0; hi = 0; first_low = 1'b0;
    do begin
      @(posedge clk); @(negedge clk); gap++;
      if (gap == 1) first_low = !div_pulse;
      if (mod_ctrl) hi++;
    end while (!div_pulse && gap < 40000);
  endtask

  task automatic run_case(input string req, input bit s, input int a, input int n,
                          input bit err_exp);
    int first, gap, hi;
    bit low;
    do_reset(s, a, n);
    check_eq(req, "ratio_err", ratio_err, err_exp);
    check_eq("R8", "mod_ctrl at release", mod_ctrl, exp_a(a, n) != 0);
    to_pulse(first);
    check_eq("R8", "first pulse edges", first, exp_gap(s, a, n) - 1);
    next_gap(gap, hi, low);
    check_eq(req, "period", gap, exp_gap(s, a, n));
    check_eq("R3", "mod_ctrl high clocks", hi, exp_hi(s, a, n));
    check_eq("R4", "pulse width one", low, 1);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    apply(1'b0, 5, 16);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_eq("R8", "div_pulse in reset", div_pulse, 0);
    check_eq("R8", "mod_ctrl in reset", mod_ctrl, 1);
    check_eq("R6", "ratio_err valid", ratio_err, 0);
  endtask

  task automatic t_midwrite();
    int first, gap, hi;
    bit low;
    do_reset(1'b0, 0, 16);
    repeat (100) begin @(posedge clk); @(negedge clk); end
    apply(1'b1, 3, 17);
    to_pulse(first);
    check_eq("R5", "old period kept", first + 100, 511);
    next_gap(gap, hi, low);
    check_eq("R5", "new period", gap, exp_gap(1'b1, 3, 17));
    check_eq("R5", "new mod_ctrl clocks", hi, exp_hi(1'b1, 3, 17));
  endtask

  task automatic t_reset_mid();
    int first;
    do_reset(1'b0, 5, 16);
    repeat (200) begin @(posedge clk); @(negedge clk); end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check_eq("R8", "mod_ctrl after mid reset", mod_ctrl, 1);
    to_pulse(first);
    check_eq("R8", "fresh period after mid reset", first, exp_gap(1'b0, 5, 16) - 1);
  endtask

  task automatic t_err_live();
    @(negedge clk);
    apply(1'b0, 10, 16);
    #1 check_eq("R6", "err clear A<N", ratio_err, 0);
    apply(1'b0, 16, 16);
    #1 check_eq("R6", "err on A==N", ratio_err, 1);
    apply(1'b0, 0, 15);
    #1 check_eq("R7", "err on N=15", ratio_err, 1);
  endtask

  initial begin
    t_reset_state();
    run_case("R1", 1'b0, 0, 16, 1'b0);     // small pair, no swallow
    run_case("R1", 1'b0, 5, 16, 1'b0);     // small pair with swallow
    run_case("R1", 1'b1, 19, 20, 1'b0);    // large pair, A = N-1
    run_case("R2", 1'b1, 127, 200, 1'b0);  // full-width swallow count
    run_case("R6", 1'b0, 30, 20, 1'b1);    // A above N
    run_case("R6", 1'b0, 20, 20, 1'b1);    // A equal to N
    run_case("R7", 1'b0, 0, 3, 1'b1);      // N below floor
    t_midwrite();
    t_reset_mid();
    t_err_live();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule